// File: doc/BRIEF.md
# Memory-Unit Command Responder

This block sits behind a two-wire peripheral bus receiver and serves requests aimed at an emulated removable memory unit. Each request comes in as a word stream. The first word is a header that holds the command, the addresses and the payload length in 32-bit words. The rest of the stream is the payload, and the receiver can flag any word of it as corrupted. Once a packet has ended, the responder decodes the command. It then either copies a 128-byte phase of a 512-byte block into a byte-addressed backing memory, or streams a block out of that memory, or returns fixed identification data. Each response leaves on a word stream with a ready handshake.

A block is written in four separate 128-byte phases. Each phase carries its own block number and phase number and is acknowledged on its own. A separate write-complete command closes the sequence. Reads return a whole block at once. The frame transmitter downstream adds the checksum and line timing. To help it, the responder provides the byte count of the frame in progress.

Top module: `mur_responder`

## Requirements
- R1: A header word is laid out as command in bits 31:24, destination in 23:16, source in 15:8 and payload length in words in 7:0. A response header puts the request's source in its destination field and the request's destination in its source field.
- R2: An info request (0x01) is answered with command 0x05 and length INFO_WORDS (28). Word 0 is FUNC_ID, word 1 is MEM_DESC, the final word is PWR_WORD, and every other word is zero.
- R3: Extended info (0x02), get condition (0x09) and memory info (0x0A) are each answered with command 0x08 and length 7. The payload is FUNC_ID followed by six fixed media descriptor words.
- R4: A block read (0x0B) is answered with command 0x08 and length 0x82. The payload is FUNC_ID, then the location word echoed back, then 128 memory words read from byte addresses block*512 + 4k in ascending k. The block number is bits 7:0 of the second payload word.
- R5: If a block read has a nonzero phase (bits 23:16 of the location word), the sticky output warn_phase is set, which only reset clears. The read is still served from byte offset 0 of the block.
- R6: A block write (0x0C) whose frame is good, whose first payload word equals FUNC_ID, and whose header length and received payload count are both 34 stores its 32 data words at byte addresses block*512 + 128*phase + 4k in ascending k. The write is then acknowledged with command 0x07 and length 0.
- R7: A block write with a flagged bad word, a wrong function identifier or a length other than 34 is still acknowledged with command 0x07 and length 0, but leaves the memory untouched.
- R8: Write complete (0x0D) is acknowledged with command 0x07 and length 0 and makes no memory access.
- R9: A command with any other code produces no response, and the block then accepts the next request.
- R10: While tx_valid is high, tx_bytes equals the response length in words times 4, plus 5.
- R11: A response word and its tx_last flag stay unchanged until tx_ready accepts them. tx_last marks the final word. rx_ready is low while a response is being sent.
- R12: After reset, tx_valid, mem_we, mem_re and warn_phase are low and rx_ready is high.
- R13: A word that arrives without rx_first while the block waits for a header is dropped, and it does not change how the next request is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_valid | input | 1 | Request word valid |
| rx_first | input | 1 | Word is a request header |
| rx_last | input | 1 | Final word of the request |
| rx_bad | input | 1 | Receiver flagged this word as corrupted |
| rx_data | input | 32 | Request word |
| rx_ready | output | 1 | Responder can take a request word |
| mem_re | output | 1 | Memory read strobe, data expected one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Response word valid |
| tx_ready | input | 1 | Transmitter accepts the response word |
| tx_data | output | 32 | Response word, header first |
| tx_last | output | 1 | Final word of the response |
| tx_bytes | output | 11 | Byte count of the frame on the wire |
| warn_phase | output | 1 | Sticky flag: a block read carried a nonzero phase |

## Verification
Some properties are checked on every cycle. A stalled response word must hold steady. Requests and responses must never overlap. Any header carrying an acknowledge must be empty and final. The wire byte count must match the length field of each header. Consecutive memory writes must step by one word. warn_phase must never fall. The directed scenarios cover the rest: the decoded content of each response kind, the address at which each phase lands, and the cases where a write is rejected. For the rejected writes, the affected blocks are read back through the block read command.

// File: rtl/mur_pkg.sv
package mur_pkg;

  localparam logic [7:0] CMD_INFO      = 8'h01;
  localparam logic [7:0] CMD_EXT_INFO  = 8'h02;
  localparam logic [7:0] CMD_INFO_RSP  = 8'h05;
  localparam logic [7:0] CMD_ACK       = 8'h07;
  localparam logic [7:0] CMD_DATA      = 8'h08;
  localparam logic [7:0] CMD_COND      = 8'h09;
  localparam logic [7:0] CMD_MEM_INFO  = 8'h0A;
  localparam logic [7:0] CMD_BLK_READ  = 8'h0B;
  localparam logic [7:0] CMD_BLK_WRITE = 8'h0C;
  localparam logic [7:0] CMD_WR_DONE   = 8'h0D;

  localparam int MEDIA_LEN = 7;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] dst;
    logic [7:0] src;
    logic [7:0] len;
  } hdr_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_COLLECT, ST_DISPATCH, ST_WRITE,
    ST_HDR, ST_PAY, ST_RD_WAIT, ST_RD_SEND
  } st_e;

  typedef enum logic [1:0] {K_ACK, K_INFO, K_MEDIA, K_READ} kind_e;

  // Media descriptor words, indexed 1..6 after the function identifier.
  function automatic logic [31:0] media_word(input logic [7:0] i);
    case (i)
      8'd1:    media_word = 32'h00FF_0000;
      8'd2:    media_word = 32'h00FE_00FF;
      8'd3:    media_word = 32'h00FD_0001;
      8'd4:    media_word = 32'h0000_000D;
      8'd5:    media_word = 32'h001F_00C8;
      8'd6:    media_word = 32'h0080_0000;
      default: media_word = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/mur_rx_capture.sv
module mur_rx_capture
  import mur_pkg::*;
#(
  parameter int PHASE_WORDS = 32,
  localparam int WCNT_W = $clog2(PHASE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_hdr,
  input  logic              take_pay,
  input  logic [31:0]       rx_data,
  input  logic              rx_bad,
  input  logic [WCNT_W-1:0] buf_idx,
  output hdr_t              hdr_o,
  output logic [31:0]       id_o,
  output logic [31:0]       loc_o,
  output logic [7:0]        cnt_o,
  output logic              bad_o,
  output logic [31:0]       buf_word_o
);

  hdr_t        hdr_q;
  logic [31:0] id_q, loc_q;
  logic [7:0]  cnt_q, cnt_d;
  logic        bad_q, bad_d;
  logic        cnt_en, id_en, loc_en;
  logic [31:0] id_d, loc_d;

  logic [PHASE_WORDS-1:0]       ld_en;
  logic [PHASE_WORDS-1:0][31:0] buf_q;

  // Payload word g+2 lands in data slot g.
  for (genvar g = 0; g < PHASE_WORDS; g++) begin : g_slot_en
    assign ld_en[g] = take_pay && (cnt_q == 8'(g + 2));
  end

  always_comb begin
    cnt_en = take_hdr || take_pay;
    cnt_d  = cnt_q;
    bad_d  = bad_q;
    id_en  = 1'b0;
    id_d   = id_q;
    loc_en = 1'b0;
    loc_d  = loc_q;
    if (take_hdr) begin
      cnt_d  = 8'd0;
      bad_d  = rx_bad;
      id_en  = 1'b1;
      id_d   = 32'd0;
      loc_en = 1'b1;
      loc_d  = 32'd0;
    end else if (take_pay) begin
      cnt_d = (cnt_q == 8'hFF) ? cnt_q : cnt_q + 8'd1;
      bad_d = bad_q | rx_bad;
      if (cnt_q == 8'd0) begin
        id_en = 1'b1;
        id_d  = rx_data;
      end
      if (cnt_q == 8'd1) begin
        loc_en = 1'b1;
        loc_d  = rx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      id_q  <= '0;
      loc_q <= '0;
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (take_hdr) hdr_q <= rx_data;
      if (id_en)    id_q  <= id_d;
      if (loc_en)   loc_q <= loc_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        bad_q <= bad_d;
      end
    end
  end

  // Data buffer is pure datapath: no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PHASE_WORDS; i++) begin
      if (ld_en[i]) buf_q[i] <= rx_data;
    end
  end

  assign hdr_o      = hdr_q;
  assign id_o       = id_q;
  assign loc_o      = loc_q;
  assign cnt_o      = cnt_q;
  assign bad_o      = bad_q;
  assign buf_word_o = buf_q[buf_idx];

endmodule

// File: rtl/mur_resp_rom.sv
module mur_resp_rom
  import mur_pkg::*;
#(
  parameter int          INFO_WORDS = 28,
  parameter logic [31:0] FUNC_ID    = 32'h0000_0002,
  parameter logic [31:0] MEM_DESC   = 32'h0010_3F00,
  parameter logic [31:0] PWR_WORD   = 32'h0064_00C8
) (
  input  logic        is_info,
  input  logic [7:0]  idx,
  output logic [31:0] word_o
);

  localparam logic [7:0] INFO_LAST = 8'(INFO_WORDS - 1);

  always_comb begin
    if (idx == 8'd0) begin
      word_o = FUNC_ID;
    end else if (is_info) begin
      if (idx == 8'd1)           word_o = MEM_DESC;
      else if (idx == INFO_LAST) word_o = PWR_WORD;
      else                       word_o = 32'd0;
    end else begin
      word_o = media_word(idx);
    end
  end

endmodule

// File: rtl/mur_ctrl.sv
module mur_ctrl
  import mur_pkg::*;
#(
  parameter int          ADDR_W      = 17,
  parameter int          BLOCK_BYTES = 512,
  parameter int          PHASE_BYTES = 128,
  parameter int          INFO_WORDS  = 28,
  parameter logic [31:0] FUNC_ID     = 32'h0000_0002,
  localparam int PHASE_WORDS = PHASE_BYTES / 4,
  localparam int WCNT_W      = $clog2(PHASE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              take_hdr,
  output logic              take_pay,
  input  hdr_t              hdr,
  input  logic [31:0]       id_word,
  input  logic [31:0]       loc_word,
  input  logic [7:0]        pay_cnt,
  input  logic              bad,
  output logic [WCNT_W-1:0] buf_idx,
  input  logic [31:0]       buf_word,
  output logic              rom_is_info,
  output logic [7:0]        rom_idx,
  input  logic [31:0]       rom_word,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic [10:0]       tx_bytes,
  output logic              warn_phase
);

  localparam int         BLK_SH    = $clog2(BLOCK_BYTES);
  localparam int         PH_SH     = $clog2(PHASE_BYTES);
  localparam logic [7:0] READ_LEN  = 8'(BLOCK_BYTES / 4 + 2);
  localparam logic [7:0] WRITE_LEN = 8'(PHASE_WORDS + 2);
  localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(PHASE_WORDS - 1);

  st_e               st_q, st_d;
  kind_e             kind_q, kind_d;
  logic [7:0]        rcmd_q, rcmd_d, rlen_q, rlen_d, idx_q, idx_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [31:0]       rd_q;
  logic              warn_q;
  logic              dec_en, idx_en, wcnt_en, rd_en, warn_en;

  logic [7:0]        blk, phase;
  logic              wr_ok, rd_mem_word, last_beat;
  logic [ADDR_W-1:0] blk_base, waddr, raddr;
  logic [31:0]       pay_word;

  assign blk   = loc_word[7:0];
  assign phase = loc_word[23:16];

  assign wr_ok = !bad && (id_word == FUNC_ID) &&
                 (pay_cnt == WRITE_LEN) && (hdr.len == WRITE_LEN);

  assign rd_mem_word = (kind_q == K_READ) && (idx_q >= 8'd2);
  assign last_beat   = (idx_q == rlen_q - 8'd1);

  assign blk_base = ADDR_W'(blk) << BLK_SH;
  assign waddr    = blk_base + (ADDR_W'(phase) << PH_SH) + (ADDR_W'(wcnt_q) << 2);
  assign raddr    = blk_base + (ADDR_W'(idx_q - 8'd2) << 2);

  assign rom_is_info = (kind_q == K_INFO);
  assign rom_idx     = idx_q;
  assign pay_word    = (kind_q == K_READ) ? ((idx_q == 8'd0) ? FUNC_ID : loc_word)
                                          : rom_word;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    rcmd_d  = rcmd_q;
    rlen_d  = rlen_q;
    idx_d   = idx_q;
    wcnt_d  = wcnt_q;
    dec_en  = 1'b0;
    idx_en  = 1'b0;
    wcnt_en = 1'b0;
    rd_en   = 1'b0;
    warn_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rx_valid && rx_first) st_d = rx_last ? ST_DISPATCH : ST_COLLECT;
      end
      ST_COLLECT: begin
        if (rx_valid && rx_last) st_d = ST_DISPATCH;
      end
      ST_DISPATCH: begin
        dec_en  = 1'b1;
        idx_en  = 1'b1;
        idx_d   = 8'd0;
        wcnt_en = 1'b1;
        wcnt_d  = '0;
        st_d    = ST_HDR;
        case (hdr.cmd)
          CMD_INFO: begin
            kind_d = K_INFO;
            rcmd_d = CMD_INFO_RSP;
            rlen_d = 8'(INFO_WORDS);
          end
          CMD_EXT_INFO, CMD_COND, CMD_MEM_INFO: begin
            kind_d = K_MEDIA;
            rcmd_d = CMD_DATA;
            rlen_d = 8'(MEDIA_LEN);
          end
          CMD_BLK_READ: begin
            kind_d  = K_READ;
            rcmd_d  = CMD_DATA;
            rlen_d  = READ_LEN;
            warn_en = (phase != 8'd0);
          end
          CMD_BLK_WRITE: begin
            kind_d = K_ACK;
            rcmd_d = CMD_ACK;
            rlen_d = 8'd0;
            if (wr_ok) st_d = ST_WRITE;
          end
          CMD_WR_DONE: begin
            kind_d = K_ACK;
            rcmd_d = CMD_ACK;
            rlen_d = 8'd0;
          end
          default: begin
            dec_en = 1'b0;
            st_d   = ST_IDLE;
          end
        endcase
      end
      ST_WRITE: begin
        wcnt_en = 1'b1;
        wcnt_d  = wcnt_q + 1'b1;
        if (wcnt_q == WLAST) st_d = ST_HDR;
      end
      ST_HDR: begin
        if (tx_ready) st_d = (rlen_q == 8'd0) ? ST_IDLE : ST_PAY;
      end
      ST_PAY: begin
        if (rd_mem_word) begin
          st_d = ST_RD_WAIT;
        end else if (tx_ready) begin
          if (last_beat) begin
            st_d = ST_IDLE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 8'd1;
          end
        end
      end
      ST_RD_WAIT: begin
        rd_en = 1'b1;
        st_d  = ST_RD_SEND;
      end
      ST_RD_SEND: begin
        if (tx_ready) begin
          if (last_beat) begin
            st_d = ST_IDLE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 8'd1;
            st_d   = ST_PAY;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_ACK;
      rcmd_q <= 8'd0;
      rlen_q <= 8'd0;
      idx_q  <= 8'd0;
      wcnt_q <= '0;
      warn_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (dec_en) begin
        kind_q <= kind_d;
        rcmd_q <= rcmd_d;
        rlen_q <= rlen_d;
      end
      if (idx_en)  idx_q  <= idx_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (warn_en) warn_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem_rdata;
  end

  // Outputs
  assign rx_ready = (st_q == ST_IDLE) || (st_q == ST_COLLECT);
  assign take_hdr = (st_q == ST_IDLE) && rx_valid && rx_first;
  assign take_pay = (st_q == ST_COLLECT) && rx_valid;

  assign mem_we    = (st_q == ST_WRITE);
  assign mem_re    = (st_q == ST_PAY) && rd_mem_word;
  assign mem_addr  = (st_q == ST_WRITE) ? waddr : raddr;
  assign buf_idx   = wcnt_q;
  assign mem_wdata = buf_word;

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 32'd0;
    tx_last  = 1'b0;
    case (st_q)
      ST_HDR: begin
        tx_valid = 1'b1;
        tx_data  = {rcmd_q, hdr.src, hdr.dst, rlen_q};
        tx_last  = (rlen_q == 8'd0);
      end
      ST_PAY: begin
        tx_valid = !rd_mem_word;
        tx_data  = pay_word;
        tx_last  = last_beat;
      end
      ST_RD_SEND: begin
        tx_valid = 1'b1;
        tx_data  = rd_q;
        tx_last  = last_beat;
      end
      default: ;
    endcase
  end

  assign tx_bytes   = {1'b0, rlen_q, 2'b00} + 11'd5;
  assign warn_phase = warn_q;

endmodule

// File: rtl/mur_responder.sv
module mur_responder
  import mur_pkg::*;
#(
  parameter int          ADDR_W      = 17,
  parameter int          BLOCK_BYTES = 512,
  parameter int          PHASE_BYTES = 128,
  parameter int          INFO_WORDS  = 28,
  parameter logic [31:0] FUNC_ID     = 32'h0000_0002,
  parameter logic [31:0] MEM_DESC    = 32'h0010_3F00,
  parameter logic [31:0] PWR_WORD    = 32'h0064_00C8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_last,
  input  logic              rx_bad,
  input  logic [31:0]       rx_data,
  output logic              rx_ready,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic [10:0]       tx_bytes,
  output logic              warn_phase
);

  localparam int PHASE_WORDS = PHASE_BYTES / 4;
  localparam int WCNT_W      = $clog2(PHASE_WORDS);

  logic              take_hdr, take_pay, bad, rom_is_info;
  hdr_t              hdr;
  logic [31:0]       id_word, loc_word, buf_word, rom_word;
  logic [7:0]        pay_cnt, rom_idx;
  logic [WCNT_W-1:0] buf_idx;

  mur_rx_capture #(.PHASE_WORDS(PHASE_WORDS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_hdr   (take_hdr),
    .take_pay   (take_pay),
    .rx_data    (rx_data),
    .rx_bad     (rx_bad),
    .buf_idx    (buf_idx),
    .hdr_o      (hdr),
    .id_o       (id_word),
    .loc_o      (loc_word),
    .cnt_o      (pay_cnt),
    .bad_o      (bad),
    .buf_word_o (buf_word)
  );

  mur_resp_rom #(
    .INFO_WORDS (INFO_WORDS),
    .FUNC_ID    (FUNC_ID),
    .MEM_DESC   (MEM_DESC),
    .PWR_WORD   (PWR_WORD)
  ) u_rom (
    .is_info (rom_is_info),
    .idx     (rom_idx),
    .word_o  (rom_word)
  );

  mur_ctrl #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .PHASE_BYTES (PHASE_BYTES),
    .INFO_WORDS  (INFO_WORDS),
    .FUNC_ID     (FUNC_ID)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_first    (rx_first),
    .rx_last     (rx_last),
    .rx_ready    (rx_ready),
    .take_hdr    (take_hdr),
    .take_pay    (take_pay),
    .hdr         (hdr),
    .id_word     (id_word),
    .loc_word    (loc_word),
    .pay_cnt     (pay_cnt),
    .bad         (bad),
    .buf_idx     (buf_idx),
    .buf_word    (buf_word),
    .rom_is_info (rom_is_info),
    .rom_idx     (rom_idx),
    .rom_word    (rom_word),
    .mem_re      (mem_re),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .tx_bytes    (tx_bytes),
    .warn_phase  (warn_phase)
  );

endmodule

// File: rtl/mur_checker.sv
module mur_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              tx_last,
  input logic [10:0]       tx_bytes,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              warn_phase
);

  // Tracks whether the next accepted response word is a header.
  logic at_hdr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   at_hdr <= 1'b1;
    else if (tx_valid && tx_ready) at_hdr <= tx_last;
  end

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r11_rx_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  a_r10_wire_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && at_hdr |-> tx_bytes == ({1'b0, tx_data[7:0], 2'b00} + 11'd5));

  a_r8_ack_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && at_hdr && tx_data[31:24] == 8'h07 |-> tx_data[7:0] == 8'h00 && tx_last);

  a_r5_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warn_phase |=> warn_phase);

  a_r6_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

bind mur_responder mur_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .tx_bytes   (tx_bytes),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr),
  .warn_phase (warn_phase)
);

// File: tb/tb_mur_responder.sv
`timescale 1ns/1ps
module tb_mur_responder;

  localparam int          AW    = 12;
  localparam int          NWORD = 1 << (AW - 2);
  localparam logic [31:0] FID   = 32'h0000_0002;
  localparam logic [31:0] DESC  = 32'h0010_3F00;
  localparam logic [31:0] PWR   = 32'h0064_00C8;
  localparam logic [7:0]  HOST  = 8'h40;
  localparam logic [7:0]  UNIT  = 8'h01;

  logic          clk, rst_n;
  logic          rx_valid, rx_first, rx_last, rx_bad, rx_ready;
  logic [31:0]   rx_data;
  logic          mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_ready, tx_last, warn_phase;
  logic [31:0]   tx_data;
  logic [10:0]   tx_bytes;

  mur_responder #(.ADDR_W(AW), .FUNC_ID(FID), .MEM_DESC(DESC), .PWR_WORD(PWR)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_last(rx_last), .rx_bad(rx_bad), .rx_data(rx_data), .rx_ready(rx_ready),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_bytes(tx_bytes), .warn_phase(warn_phase)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Backing memory model and expected image
  logic [31:0] mem [NWORD];
  logic [31:0] shadow [NWORD];
  int wr_count, rd_count;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[AW-1:2]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr[AW-1:2]];
      rd_count  <= rd_count + 1;
    end
  end

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h0001_0003) ^ 32'h3C5A_0000;
  endfunction

  function automatic logic [31:0] media_exp(int i);
    case (i)
      0: return 32'h00FF_0000;
      1: return 32'h00FE_00FF;
      2: return 32'h00FD_0001;
      3: return 32'h0000_000D;
      4: return 32'h001F_00C8;
      default: return 32'h0080_0000;
    endcase
  endfunction

  int nchk, nerr;
  logic [31:0] pay [40];
  logic [31:0] rsp [140];
  int          rsp_n;
  logic [10:0] rsp_bytes;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input logic f, input logic l, input logic b);
    @(negedge clk);
    rx_valid = 1'b1; rx_first = f; rx_last = l; rx_bad = b; rx_data = w;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send(input logic [7:0] cmd, input logic [7:0] len, input int n, input logic bad);
    push({cmd, UNIT, HOST, len}, 1'b1, n == 0, 1'b0);
    for (int i = 0; i < n; i++) push(pay[i], 1'b0, i == n - 1, bad && (i == n - 1));
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic collect(input logic bp, input int maxcyc);
    logic done;
    done  = 1'b0;
    rsp_n = 0;
    for (int c = 0; c < maxcyc && !done; c++) begin
      @(negedge clk);
      tx_ready = bp ? c[0] : 1'b1;
      if (tx_valid && tx_ready) begin
        if (rsp_n == 0) rsp_bytes = tx_bytes;
        if (rsp_n < 140) rsp[rsp_n] = tx_data;
        rsp_n++;
        if (tx_last) done = 1'b1;
      end
    end
    @(negedge clk);
    tx_ready = 1'b1;
  endtask

  task automatic t_reset;
    chk("R12 tx_valid", 32'(tx_valid), 0);
    chk("R12 mem strobes", {30'd0, mem_we, mem_re}, 0);
    chk("R12 warn_phase", 32'(warn_phase), 0);
    chk("R12 rx_ready", 32'(rx_ready), 1);
  endtask

  task automatic t_info(input string tag);
    int nz;
    send(8'h01, 8'd0, 0, 1'b0);
    collect(1'b0, 200);
    chk({tag, " R2 word count"}, rsp_n, 29);
    chk({tag, " R1 R2 header"}, rsp[0], {8'h05, HOST, UNIT, 8'd28});
    chk("R10 info bytes", 32'(rsp_bytes), 117);
    chk("R2 func id", rsp[1], FID);
    chk("R2 descriptor", rsp[2], DESC);
    chk("R2 power word", rsp[28], PWR);
    nz = 0;
    for (int i = 3; i < 28; i++) if (rsp[i] != 0) nz++;
    chk("R2 zero fill", nz, 0);
  endtask

  task automatic t_media(input logic [7:0] cmd);
    int bad_w;
    send(cmd, 8'd0, 0, 1'b0);
    collect(1'b0, 100);
    chk("R3 word count", rsp_n, 8);
    chk("R3 header", rsp[0], {8'h08, HOST, UNIT, 8'd7});
    chk("R10 media bytes", 32'(rsp_bytes), 33);
    chk("R3 func id", rsp[1], FID);
    bad_w = 0;
    for (int i = 0; i < 6; i++) if (rsp[2 + i] !== media_exp(i)) bad_w++;
    chk("R3 media words", bad_w, 0);
  endtask

  task automatic t_write(input int blk, input int ph, input logic [31:0] id, input int n,
                         input logic [7:0] len, input logic bad, input logic expect_wr,
                         input string tag);
    int w0;
    pay[0] = id;
    pay[1] = {8'h00, 8'(ph), 8'h00, 8'(blk)};
    for (int k = 0; k < 38; k++) pay[2 + k] = 32'hC0DE_0000 + 32'(blk << 8) + 32'(ph << 5) + 32'(k);
    w0 = wr_count;
    send(8'h0C, len, n, bad);
    collect(1'b0, 200);
    chk({tag, " ack count"}, rsp_n, 1);
    chk({tag, " ack header"}, rsp[0], {8'h07, HOST, UNIT, 8'd0});
    chk("R10 ack bytes", 32'(rsp_bytes), 5);
    chk({tag, " write count"}, wr_count - w0, expect_wr ? 32 : 0);
    if (expect_wr)
      for (int k = 0; k < 32; k++) shadow[blk * 128 + ph * 32 + k] = pay[2 + k];
  endtask

  task automatic t_read(input int blk, input int ph, input logic bp, input string tag);
    logic [31:0] loc;
    int bad_w;
    loc = {8'h00, 8'(ph), 8'h00, 8'(blk)};
    pay[0] = FID;
    pay[1] = loc;
    send(8'h0B, 8'd2, 2, 1'b0);
    collect(bp, 3000);
    chk({tag, " R4 word count"}, rsp_n, 131);
    chk({tag, " R4 header"}, rsp[0], {8'h08, HOST, UNIT, 8'h82});
    chk("R10 read bytes", 32'(rsp_bytes), 525);
    chk({tag, " R4 func id"}, rsp[1], FID);
    chk({tag, " R4 loc echo"}, rsp[2], loc);
    bad_w = 0;
    for (int k = 0; k < 128; k++) if (rsp[3 + k] !== shadow[blk * 128 + k]) bad_w++;
    chk({tag, " block data mismatches"}, bad_w, 0);
  endtask

  task automatic t_wr_done;
    int r0, w0;
    r0 = rd_count; w0 = wr_count;
    send(8'h0D, 8'd0, 0, 1'b0);
    collect(1'b0, 100);
    chk("R8 ack count", rsp_n, 1);
    chk("R8 ack header", rsp[0], {8'h07, HOST, UNIT, 8'd0});
    chk("R8 no memory access", (rd_count - r0) + (wr_count - w0), 0);
  endtask

  task automatic t_unknown;
    send(8'h33, 8'd0, 0, 1'b0);
    collect(1'b0, 40);
    chk("R9 no response", rsp_n, 0);
    t_info("R9 after unknown");
  endtask

  task automatic t_idle_drop;
    push(32'h0C00_0022, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    collect(1'b0, 20);
    chk("R13 stray word no response", rsp_n, 0);
    t_info("R13 after stray");
  endtask

  logic finished;

  initial begin
    for (int i = 0; i < NWORD; i++) begin
      mem[i] = pat(i);
      shadow[i] = pat(i);
    end
    nchk = 0; nerr = 0; finished = 1'b0;
    wr_count = 0; rd_count = 0;
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_bad = 1'b0; rx_data = '0;
    tx_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_info("R2");
    t_media(8'h02);
    t_media(8'h09);
    t_media(8'h0A);
    t_write(3, 2, FID, 34, 8'd34, 1'b0, 1'b1, "R6 good phase2");
    t_write(3, 0, FID, 34, 8'd34, 1'b0, 1'b1, "R6 good phase0");
    t_read(3, 0, 1'b0, "R4 block3");
    t_read(3, 0, 1'b1, "R11 backpressure");
    chk("R5 warn clear", 32'(warn_phase), 0);
    t_read(2, 1, 1'b0, "R5 phase1 read");
    chk("R5 warn set", 32'(warn_phase), 1);
    t_write(5, 1, FID, 34, 8'd34, 1'b1, 1'b0, "R7 bad frame");
    t_write(6, 1, 32'h0000_0001, 34, 8'd34, 1'b0, 1'b0, "R7 wrong id");
    t_write(7, 1, FID, 20, 8'd20, 1'b0, 1'b0, "R7 short");
    t_read(5, 0, 1'b0, "R7 block5 intact");
    t_read(6, 0, 1'b0, "R7 block6 intact");
    t_read(7, 0, 1'b0, "R7 block7 intact");
    chk("R5 warn still set", 32'(warn_phase), 1);
    t_wr_done();
    t_unknown();
    t_idle_drop();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL R11 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule